// File: doc/BRIEF.md
# PCM Serial Port with Frame-Type Detection

This block is a slave-side serial port for one voice channel on a time-division telephony bus. The bit clock is the block clock, and the frame sync pulse arrives as a synchronous input. On every frame sync pulse the port counts how many rising edges see the sync high. It then places its 8-bit slot either aligned with the pulse (long format) or one bit later (short format). In that slot it shifts out a companded byte taken from a parallel transmit input, MSB first, and drives a tri-state output enable. In the same slot it collects a byte from the serial receive line and presents it on a parallel output with a one-cycle valid strobe.

A mute request silences both directions. On the transmit side the request is latched only when a frame starts, so a byte already on the line always finishes. On the receive side the delivered byte is replaced by a silence code. A complete exchange needs frame sync pulses at least ten bit clocks apart. A faster pulse restarts the slot.

In the requirements, "cycle n" of a frame is the bit period that begins at the n-th rising edge after the first rising edge that samples frame sync high. That first edge begins cycle 0.

Top module: `pcm_frame_port`

## Requirements
- R1: While reset is asserted and after it is released, txOe and rxValid are low.
- R2: When frame sync is sampled high on two or more consecutive rising edges (long format), transmit bits appear MSB first in cycles 0 to 7, and each bit changes only at a rising edge.
- R3: When frame sync is sampled high on exactly one rising edge (short format), transmit bits appear MSB first in cycles 1 to 8.
- R4: In cycle 0, txOe is driven high only when the previous frame was detected as long format, and reset counts as short. The MSB is on txSerial in that cycle, so a short frame that follows a long one shows its MSB in both cycle 0 and cycle 1.
- R5: txOe is low outside the transmit slot, and it never goes high unless frame sync was high within the previous two edges.
- R6: Receive bits are sampled on falling edges, in cycles 0 to 7 for long format and in cycles 1 to 8 for short format, and assembled MSB first. Receive line values in all other cycles have no effect on the delivered byte.
- R7: rxValid is high for exactly one cycle per completed frame: cycle 8 for long format and cycle 9 for short format. rxByte holds the received byte in that cycle.
- R8: A mute request raised during a slot does not disturb the byte being sent. When the request is high at the start of a frame, txOe stays low for the whole of that frame.
- R9: When muteReq is high at the rising edge that ends the receive slot, rxByte carries the silence code MUTE_CODE (default 8'h00) in place of the captured byte.
- R10: The format is detected again on every frame sync pulse, so consecutive frames may alternate between long and short format.
- R11: A frame sync rising edge that arrives before the receive slot completes abandons that frame without an rxValid pulse and starts a new slot.
- R12: The transmit byte is sampled at the first rising edge that sees frame sync high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; transmit on rising edge, receive sampling on falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame sync, synchronous to clk |
| rxSerial | input | 1 | Serial receive line |
| txByte | input | WIDTH | Byte to send in the next frame |
| muteReq | input | 1 | Mute request, active high |
| txSerial | output | 1 | Serial transmit data |
| txOe | output | 1 | Transmit output enable for the external tri-state driver |
| rxByte | output | WIDTH | Last received byte, or the silence code while muted |
| rxValid | output | 1 | One-cycle strobe that marks a new rxByte |

## Verification
The hardest states to reach are the ones that depend on the previous frame. These are the cycle-0 enable decided from the last detected format, and a mute that arrives mid-slot but only takes effect on the next frame. The stimulus runs a fixed sequence of frames that alternate long and short format, including a long frame held for four edges. It raises the mute request on a chosen bit of a slot and keeps it up into the following frame. It also issues a frame sync early enough to cut a slot short, so that the abandoned capture and the restart immediately after it are observed at the ports.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;

  // Strobes from the slot controller to the shifting datapath
  typedef struct packed {
    logic load;     // take a new transmit byte
    logic shift;    // advance the transmit shifter by one bit
    logic oeNext;   // output enable for the coming bit period
    logic capture;  // receive slot complete, publish byte
  } pcmStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_RUN
  } slotState_t;

endpackage

// File: rtl/pcm_port_ctrl.sv
`timescale 1ns/1ps
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fs,
  input  logic        muteReq,
  output pcmStrobes_t strb
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  slotState_t       state;
  logic             fsPrev;
  logic             isLong;
  logic             muteActive;
  logic [CNT_W-1:0] bitIdx;
  logic             fsRise;
  logic             lastBit;

  assign fsRise  = fs & ~fsPrev;
  assign lastBit = (bitIdx == LAST);

  always_comb begin
    strb = '0;
    strb.load = fsRise;
    if (fsRise) begin
      // cycle 0: enable only if the format seen last time was long
      strb.oeNext = isLong & ~muteReq;
    end else begin
      case (state)
        ST_DECIDE: begin
          strb.oeNext = ~muteActive;
          strb.shift  = fs;          // long: move on to bit two
        end
        ST_RUN: begin
          strb.oeNext  = ~lastBit & ~muteActive;
          strb.shift   = ~lastBit;
          strb.capture = lastBit;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      fsPrev     <= 1'b0;
      isLong     <= 1'b0;
      muteActive <= 1'b0;
      bitIdx     <= '0;
    end else begin
      fsPrev <= fs;
      if (fsRise) begin
        state      <= ST_DECIDE;
        bitIdx     <= '0;
        muteActive <= muteReq;
      end else begin
        case (state)
          ST_DECIDE: begin
            isLong <= fs;
            bitIdx <= fs ? CNT_W'(1) : '0;
            state  <= ST_RUN;
          end
          ST_RUN: begin
            if (lastBit) state <= ST_IDLE;
            else         bitIdx <= bitIdx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R11: a completed slot always returns to idle unless a new pulse restarts it
  p_slot_closes_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && lastBit && !fsRise) |=> (state == ST_IDLE));

endmodule

// File: rtl/pcm_port_dp.sv
`timescale 1ns/1ps
module pcm_port_dp
  import pcm_port_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] MUTE_CODE = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcmStrobes_t      strb,
  input  logic             rxSerial,
  input  logic [WIDTH-1:0] txByte,
  input  logic             muteReq,
  output logic             txSerial,
  output logic             txOe,
  output logic [WIDTH-1:0] rxByte,
  output logic             rxValid
);

  logic [WIDTH-1:0] txShift;
  logic [WIDTH-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txOe    <= 1'b0;
    end else begin
      txOe <= strb.oeNext;
      if (strb.load)       txShift <= txByte;
      else if (strb.shift) txShift <= {txShift[WIDTH-2:0], 1'b0};
    end
  end

  assign txSerial = txShift[WIDTH-1];

  // receive line sampled mid-bit; the window is chosen by the capture strobe
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else       rxShift <= {rxShift[WIDTH-2:0], rxSerial};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strb.capture;
      if (strb.capture) rxByte <= muteReq ? MUTE_CODE : rxShift;
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_valid_slot_closed_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !txOe);

endmodule

// File: rtl/pcm_frame_port.sv
`timescale 1ns/1ps
module pcm_frame_port
  import pcm_port_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] MUTE_CODE = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic             rxSerial,
  input  logic [WIDTH-1:0] txByte,
  input  logic             muteReq,
  output logic             txSerial,
  output logic             txOe,
  output logic [WIDTH-1:0] rxByte,
  output logic             rxValid
);

  pcmStrobes_t strb;

  pcm_port_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fs      (frameSync),
    .muteReq (muteReq),
    .strb    (strb)
  );

  pcm_port_dp #(.WIDTH(WIDTH), .MUTE_CODE(MUTE_CODE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rxSerial (rxSerial),
    .txByte   (txByte),
    .muteReq  (muteReq),
    .txSerial (txSerial),
    .txOe     (txOe),
    .rxByte   (rxByte),
    .rxValid  (rxValid)
  );

  p_oe_needs_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOe) |-> ($past(frameSync) || $past(frameSync, 2)));

  p_mute_blocks_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !$past(frameSync) && muteReq) |=> !txOe);

  p_mute_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(muteReq)) |-> (rxByte == MUTE_CODE));

endmodule

// File: tb/sim_pcm_frame_port.sv
`timescale 1ns/1ps
module sim_pcm_frame_port;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameSync;
  logic       rxSerial;
  logic [7:0] txByte;
  logic       muteReq;
  logic       txSerial;
  logic       txOe;
  logic [7:0] rxByte;
  logic       rxValid;

  always #2.5 clk = ~clk;

  pcm_frame_port u0 (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .rxSerial  (rxSerial),
    .txByte    (txByte),
    .muteReq   (muteReq),
    .txSerial  (txSerial),
    .txOe      (txOe),
    .rxByte    (rxByte),
    .rxValid   (rxValid)
  );

  typedef struct {
    logic [7:0] data;
    int         cyc;
    string      tag;
  } rxExp_t;

  rxExp_t expQ[$];
  int     checks = 0;
  int     failures = 0;
  int     cycleCnt = 0;
  bit     prevLong = 1'b0;
  bit     finished = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard whenever a byte is published
  initial begin
    forever begin
      rxExp_t e;
      @(posedge clk);
      #1.25;
      if (rxValid === 1'b1) begin
        if (expQ.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R11 or R7 unexpected rxValid actual=1 expected=0");
        end else begin
          e = expQ.pop_front();
          check("R7", "valid cycle", cycleCnt, e.cyc);
          check(e.tag, "rx byte", {24'h0, rxByte}, {24'h0, e.data});
        end
      end
    end
  end

  // driver: one frame; called just after a falling edge
  task automatic runFrame(input bit lng, input int hold, input int period,
                          input logic [7:0] txb, input logic [7:0] rxb,
                          input bit muteStart, input int muteMid);
    int  capCyc;
    int  first;
    bit  pred;
    bit  muteCap;
    bit  eOe;
    bit  eBit;
    string tag;
    capCyc  = lng ? 8 : 9;
    first   = lng ? 0 : 1;
    pred    = prevLong;
    muteCap = muteStart || (muteMid >= 0 && muteMid < capCyc);
    frameSync = 1'b1;
    txByte    = txb;
    muteReq   = muteStart;
    for (int c = 0; c < period; c++) begin
      @(posedge clk);
      #1;
      if (c == 0 && period > capCyc) begin
        rxExp_t e;
        e.data = muteCap ? 8'h00 : rxb;
        e.cyc  = cycleCnt + capCyc;
        e.tag  = muteCap ? "R9" : "R6";
        expQ.push_back(e);
      end
      if (c == 1) prevLong = lng;
      txByte = ~txb;  // changes after the load edge must not matter (R12)
      if (c >= first && c < first + 8) rxSerial = rxb[7 - (c - first)];
      else                             rxSerial = ~rxb[c % 8];
      if (muteMid == c) muteReq = 1'b1;
      #0.25;
      if (c == 0) begin
        eOe  = pred & ~muteStart;
        eBit = txb[7];
        tag  = muteStart ? "R8" : "R4";
      end else if (c < first + 8) begin
        eOe  = ~muteStart;
        eBit = txb[7 - (c - first)];
        tag  = muteStart ? "R8" : (lng ? "R2" : "R3");
      end else begin
        eOe  = 1'b0;
        eBit = 1'b0;
        tag  = "R5";
      end
      check(tag, "txOe", {31'h0, txOe}, {31'h0, eOe});
      if (eOe) check(tag, "txSerial", {31'h0, txSerial}, {31'h0, eBit});
      @(negedge clk);
      #1;
      frameSync = (c + 1 < hold);
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1.25;
      check("R5", "idle txOe", {31'h0, txOe}, 32'h0);
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    rstN = 1'b0; frameSync = 1'b0; rxSerial = 1'b0; txByte = 8'h00; muteReq = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "reset txOe", {31'h0, txOe}, 32'h0);
    check("R1", "reset rxValid", {31'h0, rxValid}, 32'h0);
    #1 rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "post-reset txOe", {31'h0, txOe}, 32'h0);
    // lng, hold, period, tx, rx, muteStart, muteMid
    runFrame(1, 2, 12, 8'hA5, 8'h3C, 0, -1);  // R2, R4 first long after reset
    runFrame(1, 2, 12, 8'h81, 8'hC3, 0, -1);  // R2 predicted long
    runFrame(0, 1, 12, 8'h5A, 8'h96, 0, -1);  // R3, R4 early MSB, R10
    runFrame(0, 1, 12, 8'h0F, 8'hF0, 0, -1);  // R3 predicted short
    runFrame(1, 4, 12, 8'hC6, 8'h6B, 0, -1);  // R2 wide sync
    runFrame(1, 2, 12, 8'h99, 8'h77, 0, 3);   // R8 mid-slot mute, R9
    runFrame(1, 2, 12, 8'h42, 8'h24, 1, -1);  // R8 muted frame
    runFrame(0, 1, 12, 8'hE1, 8'h1E, 0, -1);  // R10 unmuted short
    runFrame(1, 2, 6,  8'h3F, 8'hFC, 0, -1);  // R11 cut short
    runFrame(1, 2, 12, 8'hB4, 8'h4B, 0, -1);  // R11 restart
    runFrame(0, 1, 32, 8'h6D, 8'hD6, 0, -1);  // R6 long gap
    runFrame(1, 2, 10, 8'h12, 8'h21, 0, -1);  // R10 minimum spacing
    runFrame(0, 1, 10, 8'hFE, 8'h01, 0, -1);
    frameSync = 1'b0;
    idleCycles(6);
    check("R7", "pending bytes", expQ.size(), 32'h0);
    endRun();
  end

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    endRun();
  end

endmodule